// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs single management transactions on a two-wire serial bus that reaches a network PHY: a clock line (`mdc`) it generates itself and a bidirectional data line, carried here as a driven value (`mdio_o`), an output-enable (`mdio_oe`) and a sampled input (`mdio_i`). The pad is expected to sit outside the block. A host pulses `start` while presenting a read/write select, a PHY address, a register address and, for writes, a data word. The master then emits the whole frame, returns read data, and pulses `done`.

Each transaction is wrapped in a run of ones on both sides. Before the command there is a preamble of `PRE_LEN` bit slots with the line driven high. After the data phase there is a trailer of `POST_LEN` slots, also driven high. Writes shift out the full command word. Reads shift out only the header. They then release the line for one turnaround slot and clock in sixteen bits from the PHY.

The clock rate comes from the `half_cycles` input, the number of system clock cycles in each half of the bus clock. The value is taken when a transaction starts. At a 50 MHz system clock, a value of 50 gives the roughly 2 µs bus period that management devices expect.

Top module: `mdio_frame_master`

## Requirements
- R1: During and after synchronous reset, `mdc` is 1, `mdio_oe` is 0, `mdio_o` is 1, `done` and `busy` are 0 and `rd_data` is 0. Whenever the master is idle, `mdc` stays 1 and the line is released.
- R2: Every transaction opens with 32 bit slots in which `mdio_oe` is 1 and `mdio_o` is 1.
- R3: The command word is 32 bits and is sent most significant bit first. Bits 31:30 hold the start code 01. Bits 29:28 hold the opcode, 10 for read and 01 for write. Bits 27:23 hold the PHY address and bits 22:18 the register address. Bits 17:16 hold the turnaround code 10 and bits 15:0 the write data. A write sends all 32 bits.
- R4: A read sends only bits 31:18 (14 slots). It then leaves `mdio_oe` low for one turnaround slot and 16 data slots. It samples `mdio_i` at each rising `mdc` of the data slots, first bit as bit 15, and shows the result on `rd_data` when `done` pulses. A write leaves `rd_data` unchanged.
- R5: After the command or read data, 32 more slots are sent with `mdio_oe` 1 and `mdio_o` 1. `done` follows at the end of the last of them.
- R6: Each low and high half of `mdc` lasts `half_cycles` system cycles, and a value of 0 acts as 1. The value is captured at start, so later changes do not affect the running transaction. `done` is seen 2·H·N cycles after the accepting edge, where N is 96 for a write and 95 for a read.
- R7: `mdio_o` changes only at the edge where `mdc` falls, so it is stable across every rising edge.
- R8: `busy` is high from the cycle after `start` is accepted until `done`, which lasts exactly one cycle. A `start` seen while busy is ignored, along with any change to the request inputs.
- R9: `mdio_oe` is high during preamble, command, write data and trailer. It is low during the read turnaround and read data. It changes only where `mdc` falls or where `done` is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a transaction (accepted only when idle) |
| rd_not_wr | input | 1 | 1 selects a read, 0 a write |
| phy_addr | input | PHY_AW (5) | PHY address |
| reg_addr | input | REG_AW (5) | Register address |
| wr_data | input | DATA_W (16) | Data to write |
| half_cycles | input | DIV_W (8) | System cycles per half bus clock |
| mdio_i | input | 1 | Sampled data line |
| rd_data | output | DATA_W (16) | Data returned by the last read |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Transaction in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven on the data line |
| mdio_oe | output | 1 | Drive enable for the data line |

## Verification
The assertions make several assumptions about the environment:
- Reset is held for at least two clock edges.
- `start` is a synchronous level that the block may see while busy.
- `mdio_i` may carry any value outside the read data slots, because the master must not look at it there.

The stimulus keeps within these bounds in the following ways. It drives every input at the falling system clock edge. It presents PHY data on the falling bus clock that precedes each sampling edge, and puts random noise on `mdio_i` in every other slot. It keeps `half_cycles` small, 0 to 3, so that many random frames fit in the run. Mid-transaction `start` pulses come with inverted request fields, so any leak into the frame would show.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   typedef enum logic [2:0] {
      SEG_IDLE,
      SEG_PRE,
      SEG_CMD,
      SEG_TURN,
      SEG_RDAT,
      SEG_POST
   } seg_e;

   localparam logic [1:0] SOF_CODE  = 2'b01;
   localparam logic [1:0] OP_READ   = 2'b10;
   localparam logic [1:0] OP_WRITE  = 2'b01;
   localparam logic [1:0] TURN_CODE = 2'b10;
endpackage

// File: rtl/mdio_clk_gen.sv
// Bus clock generator: low half then high half per bit slot.
module mdio_clk_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic             run,
   input  logic             last_slot,
   input  logic [DIV_W-1:0] half_cycles,
   output logic             mdc,
   output logic             rise_now,
   output logic             slot_end
);
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] lim_q;
   logic             at_lim;

   assign at_lim   = (cnt_q == lim_q);
   assign rise_now = run && !load && at_lim && !mdc;
   assign slot_end = run && !load && at_lim && mdc;

   always_ff @(posedge clk) begin
      if (rst) begin
         mdc   <= 1'b1;
         cnt_q <= '0;
         lim_q <= '0;
      end else if (load) begin
         mdc   <= 1'b0;
         cnt_q <= '0;
         lim_q <= (half_cycles == '0) ? '0 : half_cycles - 1'b1;
      end else if (run) begin
         if (at_lim) begin
            cnt_q <= '0;
            if (!mdc)
               mdc <= 1'b1;
            else if (!last_slot)
               mdc <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/mdio_frame_seq.sv
// Slot sequencer: preamble, command, turnaround, read data, trailer.
module mdio_frame_seq
   import mdio_pkg::*;
#(
   parameter int PHY_AW   = 5,
   parameter int REG_AW   = 5,
   parameter int DATA_W   = 16,
   parameter int PRE_LEN  = 32,
   parameter int POST_LEN = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              rd_not_wr,
   input  logic [PHY_AW-1:0] phy_addr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rise_now,
   input  logic              slot_end,
   input  logic              mdio_i,
   output logic              accept,
   output logic              last_slot,
   output logic              busy,
   output logic              done,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic [DATA_W-1:0] rd_data
);
   localparam int HDR_W   = 4 + PHY_AW + REG_AW;
   localparam int FRAME_W = HDR_W + 2 + DATA_W;
   localparam int MAXLEN0 = (PRE_LEN > POST_LEN) ? PRE_LEN : POST_LEN;
   localparam int MAXLEN  = (MAXLEN0 > FRAME_W) ? MAXLEN0 : FRAME_W;
   localparam int CNT_W   = $clog2(MAXLEN + 1);

   localparam logic [CNT_W-1:0] PRE_LAST  = CNT_W'(PRE_LEN - 1);
   localparam logic [CNT_W-1:0] POST_LAST = CNT_W'(POST_LEN - 1);
   localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_W - 1);
   localparam logic [CNT_W-1:0] FRM_LAST  = CNT_W'(FRAME_W - 1);
   localparam logic [CNT_W-1:0] DAT_LAST  = CNT_W'(DATA_W - 1);

   seg_e               seg_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [FRAME_W-1:0] frame_q;
   logic [FRAME_W-1:0] frame_new;
   logic [DATA_W-1:0]  rsh_q;
   logic               is_rd_q;
   logic               cmd_last;

   assign frame_new = {SOF_CODE, rd_not_wr ? OP_READ : OP_WRITE, phy_addr, reg_addr,
                       TURN_CODE, rd_not_wr ? {DATA_W{1'b0}} : wr_data};
   assign busy      = (seg_q != SEG_IDLE);
   assign accept    = start && !busy;
   assign cmd_last  = is_rd_q ? (cnt_q == HDR_LAST) : (cnt_q == FRM_LAST);
   assign last_slot = (seg_q == SEG_POST) && (cnt_q == POST_LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         seg_q   <= SEG_IDLE;
         cnt_q   <= '0;
         frame_q <= '0;
         rsh_q   <= '0;
         is_rd_q <= 1'b0;
         done    <= 1'b0;
         mdio_o  <= 1'b1;
         mdio_oe <= 1'b0;
         rd_data <= '0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            seg_q   <= SEG_PRE;
            cnt_q   <= '0;
            frame_q <= frame_new;
            is_rd_q <= rd_not_wr;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b1;
         end else begin
            if (rise_now && seg_q == SEG_RDAT)
               rsh_q <= {rsh_q[DATA_W-2:0], mdio_i};
            if (slot_end) begin
               cnt_q <= cnt_q + 1'b1;
               unique case (seg_q)
                  SEG_PRE: begin
                     if (cnt_q == PRE_LAST) begin
                        seg_q   <= SEG_CMD;
                        cnt_q   <= '0;
                        mdio_o  <= frame_q[FRAME_W-1];
                        frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
                     end
                  end
                  SEG_CMD: begin
                     if (cmd_last) begin
                        cnt_q <= '0;
                        if (is_rd_q) begin
                           seg_q   <= SEG_TURN;
                           mdio_oe <= 1'b0;
                        end else begin
                           seg_q  <= SEG_POST;
                           mdio_o <= 1'b1;
                        end
                     end else begin
                        mdio_o  <= frame_q[FRAME_W-1];
                        frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
                     end
                  end
                  SEG_TURN: begin
                     seg_q <= SEG_RDAT;
                     cnt_q <= '0;
                  end
                  SEG_RDAT: begin
                     if (cnt_q == DAT_LAST) begin
                        seg_q   <= SEG_POST;
                        cnt_q   <= '0;
                        mdio_o  <= 1'b1;
                        mdio_oe <= 1'b1;
                     end
                  end
                  SEG_POST: begin
                     if (cnt_q == POST_LAST) begin
                        seg_q   <= SEG_IDLE;
                        cnt_q   <= '0;
                        mdio_oe <= 1'b0;
                        done    <= 1'b1;
                        if (is_rd_q)
                           rd_data <= rsh_q;
                     end
                  end
                  default: seg_q <= SEG_IDLE;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master #(
   parameter int DIV_W    = 8,
   parameter int PHY_AW   = 5,
   parameter int REG_AW   = 5,
   parameter int DATA_W   = 16,
   parameter int PRE_LEN  = 32,
   parameter int POST_LEN = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              rd_not_wr,
   input  logic [PHY_AW-1:0] phy_addr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DIV_W-1:0]  half_cycles,
   input  logic              mdio_i,
   output logic [DATA_W-1:0] rd_data,
   output logic              done,
   output logic              busy,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe
);
   initial begin
      if (DIV_W < 1)    $fatal(1, "DIV_W must be at least 1");
      if (DATA_W < 2)   $fatal(1, "DATA_W must be at least 2");
      if (PRE_LEN < 1)  $fatal(1, "PRE_LEN must be at least 1");
      if (POST_LEN < 1) $fatal(1, "POST_LEN must be at least 1");
   end

   logic accept;
   logic last_slot;
   logic rise_now;
   logic slot_end;

   mdio_clk_gen #(.DIV_W(DIV_W)) u_clk (
      .clk        (clk),
      .rst        (rst),
      .load       (accept),
      .run        (busy),
      .last_slot  (last_slot),
      .half_cycles(half_cycles),
      .mdc        (mdc),
      .rise_now   (rise_now),
      .slot_end   (slot_end)
   );

   mdio_frame_seq #(
      .PHY_AW  (PHY_AW),
      .REG_AW  (REG_AW),
      .DATA_W  (DATA_W),
      .PRE_LEN (PRE_LEN),
      .POST_LEN(POST_LEN)
   ) u_seq (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .rd_not_wr(rd_not_wr),
      .phy_addr (phy_addr),
      .reg_addr (reg_addr),
      .wr_data  (wr_data),
      .rise_now (rise_now),
      .slot_end (slot_end),
      .mdio_i   (mdio_i),
      .accept   (accept),
      .last_slot(last_slot),
      .busy     (busy),
      .done     (done),
      .mdio_o   (mdio_o),
      .mdio_oe  (mdio_oe),
      .rd_data  (rd_data)
   );
endmodule

// File: rtl/mdio_frame_master_chk.sv
module mdio_frame_master_chk (
   input logic clk,
   input logic rst,
   input logic start,
   input logic busy,
   input logic done,
   input logic mdc,
   input logic mdio_o,
   input logic mdio_oe
);
   assert_idle_released_R1: assert property (@(posedge clk) disable iff (rst)
      !busy |-> (mdc && !mdio_oe));

   assert_idle_line_high_R5: assert property (@(posedge clk) disable iff (rst)
      !busy |-> mdio_o);

   assert_data_on_fall_R7: assert property (@(posedge clk) disable iff (rst)
      !$stable(mdio_o) |-> $fell(mdc));

   assert_oe_on_fall_R9: assert property (@(posedge clk) disable iff (rst)
      !$stable(mdio_oe) |-> ($fell(mdc) || done));

   assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   assert_busy_ends_done_R8: assert property (@(posedge clk) disable iff (rst)
      (!busy && $past(busy)) |-> done);

   assert_busy_from_start_R8: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> $past(start));
endmodule

bind mdio_frame_master mdio_frame_master_chk u_chk (
   .clk    (clk),
   .rst    (rst),
   .start  (start),
   .busy   (busy),
   .done   (done),
   .mdc    (mdc),
   .mdio_o (mdio_o),
   .mdio_oe(mdio_oe)
);

// File: tb/mdio_frame_master_test.sv
module mdio_frame_master_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic        rd_not_wr = 1'b0;
   logic [4:0]  phy_addr = '0;
   logic [4:0]  reg_addr = '0;
   logic [15:0] wr_data = '0;
   logic [7:0]  half_cycles = 8'd1;
   logic        mdio_i = 1'b1;
   logic [15:0] rd_data;
   logic        done, busy, mdc, mdio_o, mdio_oe;

   int checks = 0;
   int fails = 0;
   int nrise = 0;
   int nfall = 0;
   int cyc = 0;
   logic [1:0]  rec [0:127];
   logic        cur_rd = 1'b0;
   logic [15:0] cur_val = '0;

   always #10 clk = ~clk;

   mdio_frame_master uut (
      .clk(clk), .rst(rst), .start(start), .rd_not_wr(rd_not_wr),
      .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
      .half_cycles(half_cycles), .mdio_i(mdio_i), .rd_data(rd_data),
      .done(done), .busy(busy), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
   );

   always @(posedge mdc) begin
      if (nrise < 128) rec[nrise] = {mdio_oe, mdio_o};
      nrise++;
   end

   // PHY model: present read data on the fall before each sampling rise
   always @(negedge mdc) begin
      if (cur_rd && nfall >= 47 && nfall < 63)
         mdio_i = cur_val[15 - (nfall - 47)];
      else
         mdio_i = 1'($urandom_range(0, 1));
      nfall++;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         chk(1'b0, "watchdog R8", cyc, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   function automatic logic [1:0] exp_slot(input bit rd, input logic [4:0] pa,
                                           input logic [4:0] ra, input logic [15:0] wd,
                                           input int idx);
      logic [31:0] fr;
      fr = {2'b01, rd ? 2'b10 : 2'b01, pa, ra, 2'b10, rd ? 16'h0 : wd};
      if (idx < 32) return 2'b11;
      if (rd) begin
         if (idx < 46) return {1'b1, fr[31 - (idx - 32)]};
         if (idx < 63) return 2'b00;
         return 2'b11;
      end
      if (idx < 64) return {1'b1, fr[31 - (idx - 32)]};
      return 2'b11;
   endfunction

   task automatic run_txn(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                          input logic [15:0] wd, input logic [15:0] pv,
                          input logic [7:0] hc, input int inject_at);
      int n, heff, nslots;
      int bad_pre, bad_cmd, bad_rd, bad_post;
      logic [1:0]  e;
      logic [15:0] prev_rd;
      @(negedge clk);
      prev_rd = rd_data;
      cur_rd = rd; cur_val = pv; nrise = 0; nfall = 0;
      rd_not_wr = rd; phy_addr = pa; reg_addr = ra; wr_data = wd; half_cycles = hc;
      start = 1'b1;
      n = 0;
      while (1) begin
         @(posedge clk);
         n++;
         @(negedge clk);
         start = 1'b0;
         if (n == inject_at) begin
            start = 1'b1; rd_not_wr = ~rd; phy_addr = ~pa; reg_addr = ~ra;
            wr_data = ~wd; half_cycles = hc + 8'd2;
         end
         if (done) break;
         if (n > 6000) begin
            chk(1'b0, "R8 done missing", n, 0);
            return;
         end
      end
      heff = (hc == 0) ? 1 : int'(hc);
      nslots = rd ? 95 : 96;
      chk(n == 2 * heff * nslots + 1, "R6 cycles to done", n, 2 * heff * nslots + 1);
      chk(busy == 1'b0, "R8 busy low at done", busy, 0);
      chk(nrise == nslots, "R2/R5 slot count", nrise, nslots);
      bad_pre = 0; bad_cmd = 0; bad_rd = 0; bad_post = 0;
      for (int i = 0; i < nslots && i < 128; i++) begin
         e = exp_slot(rd, pa, ra, wd, i);
         if (rec[i][1] !== e[1] || (e[1] && rec[i][0] !== e[0])) begin
            if (i < 32) bad_pre++;
            else if (i >= nslots - 32) bad_post++;
            else if (rd && i >= 46) bad_rd++;
            else bad_cmd++;
         end
      end
      chk(bad_pre == 0, "R2 preamble slots", bad_pre, 0);
      chk(bad_cmd == 0, "R3 command bits", bad_cmd, 0);
      chk(bad_post == 0, "R5 trailer slots", bad_post, 0);
      if (rd) begin
         chk(bad_rd == 0, "R9 line released in turnaround/data", bad_rd, 0);
         chk(rd_data == pv, "R4 read data", rd_data, pv);
      end else begin
         chk(rd_data == prev_rd, "R4 write keeps rd_data", rd_data, prev_rd);
      end
      @(negedge clk);
      chk(done == 1'b0, "R8 done one cycle", done, 0);
      chk(mdc && !mdio_oe, "R1 idle clock high line released", {mdc, mdio_oe}, 2'b10);
   endtask

   initial begin
      void'($urandom(32'd24681));
      repeat (3) @(negedge clk);
      chk(mdc == 1'b1 && mdio_oe == 1'b0 && mdio_o == 1'b1, "R1 reset pins",
          {mdc, mdio_oe, mdio_o}, 3'b101);
      chk(done == 1'b0 && busy == 1'b0 && rd_data == 16'h0, "R1 reset status",
          {done, busy, rd_data}, 0);
      rst = 1'b0;

      // directed corners
      run_txn(1'b0, 5'd0, 5'd0, 16'hFFFF, 16'h0, 8'd0, 0);          // R6 zero divider
      run_txn(1'b1, 5'd31, 5'd31, 16'h0, 16'hA5C3, 8'd1, 0);        // R4
      run_txn(1'b0, 5'h15, 5'h0A, 16'h8001, 16'h0, 8'd2, 50);       // R8 ignored start
      run_txn(1'b1, 5'h01, 5'h10, 16'h0, 16'h0001, 8'd1, 120);      // R8 ignored start in read
      run_txn(1'b1, 5'h00, 5'h00, 16'h0, 16'h8000, 8'd3, 0);

      // constrained random
      for (int k = 0; k < 16; k++) begin
         run_txn(1'($urandom_range(0, 1)), 5'($urandom), 5'($urandom), 16'($urandom),
                 16'($urandom), 8'($urandom_range(0, 3)),
                 ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 150)) : 0);
      end

      // reset in the middle of a read
      @(negedge clk);
      rd_not_wr = 1'b1; phy_addr = 5'd3; reg_addr = 5'd4; half_cycles = 8'd2; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (80) @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      chk(mdc == 1'b1 && mdio_oe == 1'b0 && busy == 1'b0 && done == 1'b0,
          "R1 reset mid transaction", {mdc, mdio_oe, busy, done}, 4'b1000);
      chk(rd_data == 16'h0, "R1 reset clears rd_data", rd_data, 0);
      rst = 1'b0;
      run_txn(1'b1, 5'd9, 5'd2, 16'h0, 16'h3C5A, 8'd1, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule